// File: doc/BRIEF.md
# Three-Source Sticky Interrupt Combiner

This block merges three interrupt sources into one active-low, open-drain interrupt request. The sources are a periodic tick, an alarm match and an update-complete event. Each arrives as a one-cycle pulse from logic outside the block. Every pulse sets a sticky flag. The flag stays set until software reads the status byte or the hardware reset is asserted.

A three-bit enable register decides which flags may pull the interrupt line low. The status byte reports the raw flags together with a summary bit that matches the state of the line. Reading the status byte clears all three flags. A pulse that lands in the same cycle as that read survives the clear, so no event is lost.

The pad itself sits outside the block. The block only produces the pull-low enable: when that enable is 0, the pad floats. All interfaces here are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A pulse on `evt_periodic`, `evt_alarm` or `evt_update` sets its flag at the next rising clock edge, whether or not that source is enabled. Flags appear in `stat_q` at bit 6 (periodic), bit 5 (alarm) and bit 4 (update).
- R2: A set flag stays set on every later edge until either a status read or reset clears it.
- R3: `irq_pull` is 1 exactly when at least one flag is set and its enable bit is also set. Otherwise it is 0, which leaves the pad floating.
- R4: `stat_q` bit 7 always equals `irq_pull`. Bits 3 to 0 always read 0.
- R5: A cycle with `stat_rd` high presents the flags as they stand before the clear. At that edge, every flag whose source is not pulsing is cleared.
- R6: A source pulse that coincides with `stat_rd` leaves its flag set after the edge.
- R7: `en_wr` loads `en_wdata` into the enable register at the next edge. The bit order is bit 2 periodic, bit 1 alarm, bit 0 update. Enabling a flag that is already pending asserts `irq_pull` in that same update.
- R8: While `rst_n` is low, all enables and flags are cleared and `irq_pull` is 0. After release, the enables stay 0 until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic | input | 1 | One-cycle periodic tick |
| evt_alarm | input | 1 | One-cycle alarm match |
| evt_update | input | 1 | One-cycle update-complete event |
| en_wr | input | 1 | Load strobe for the enable register |
| en_wdata | input | 3 | New enables: bit 2 periodic, bit 1 alarm, bit 0 update |
| stat_rd | input | 1 | Status read strobe; clears the flags at the edge |
| stat_q | output | 8 | Status byte: bit 7 summary, bits 6..4 flags, bits 3..0 zero |
| irq_pull | output | 1 | Open-drain pull-low enable for the interrupt pad |

## Verification
A vector table drives each source alone, with its own enable set and with it clear, and with several sources pending at once. These cases separate flag setting from output gating. Reads are issued with and without a coincident source pulse. This tells a correct clear-then-set priority apart from one that loses events or fails to clear. The enable register is rewritten while flags are pending, to show the output tracks the enables and does not latch a stale condition. A reset applied mid-activity confirms that the flags and enables return to zero.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned FLAG_LSB = 4;
  localparam int unsigned SUM_BIT  = 7;
  localparam int unsigned SRC_PER  = 2;
  localparam int unsigned SRC_ALM  = 1;
  localparam int unsigned SRC_UPD  = 0;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_bit_i,
  output logic flag_o,
  output logic en_o,
  output logic req_o
);
  logic flag_q;
  logic en_q;

  // Clear-on-read loses to a coincident event so nothing is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (evt_i) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_wr_i) begin
      en_q <= en_bit_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign req_o  = flag_q & en_q;

  p_flag_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_o);
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !flag_o);
  p_enable_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_o == $past(en_bit_i)));
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned ST_W  = STAT_W,
  parameter int unsigned F_LSB = FLAG_LSB,
  parameter int unsigned S_BIT = SUM_BIT
) (
  input  logic [N_SRC-1:0] flags_i,
  input  logic [N_SRC-1:0] reqs_i,
  output logic             summary_o,
  output logic [ST_W-1:0]  stat_o
);
  localparam int unsigned F_MSB = F_LSB + N_SRC - 1;

  assign summary_o = |reqs_i;

  always_comb begin
    stat_o = '0;
    stat_o[F_MSB:F_LSB] = flags_i;
    stat_o[S_BIT] = summary_o;
  end

  always_comb begin
    p_low_zero_r4: assert (stat_o[F_LSB-1:0] == '0);
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_periodic,
  input  logic                evt_alarm,
  input  logic                evt_update,
  input  logic                en_wr,
  input  logic [NUM_SRC-1:0]  en_wdata,
  input  logic                stat_rd,
  output logic [STAT_W-1:0]   stat_q,
  output logic                irq_pull
);
  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] flag_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] req_vec;
  logic               summary;

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_PER] = evt_periodic;
    evt_vec[SRC_ALM] = evt_alarm;
    evt_vec[SRC_UPD] = evt_update;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_flag_cell i_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_vec[g]),
      .clr_i    (stat_rd),
      .en_wr_i  (en_wr),
      .en_bit_i (en_wdata[g]),
      .flag_o   (flag_vec[g]),
      .en_o     (en_vec[g]),
      .req_o    (req_vec[g])
    );
  end

  irq_combine i_comb (
    .flags_i   (flag_vec),
    .reqs_i    (req_vec),
    .summary_o (summary),
    .stat_o    (stat_q)
  );

  assign irq_pull = summary;

  p_pull_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> (stat_q[FLAG_LSB +: NUM_SRC] != '0));
  p_summary_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[SUM_BIT] == irq_pull);
  p_read_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !evt_periodic && !evt_alarm && !evt_update) |=> !irq_pull);
  p_keep_coincident_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_alarm) |=> stat_q[FLAG_LSB + SRC_ALM]);
  p_no_pull_without_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_wdata == '0) |=> !irq_pull);
endmodule

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam int WATCHDOG = 5000;

  // {en_wr, en_wdata[2:0], evt{p,a,u}, rd, exp_stat[7:0], exp_pull}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 3'b000, 3'b100, 1'b0, 8'h40, 1'b0},  // R1 flag without enable
    {1'b1, 3'b100, 3'b000, 1'b0, 8'hC0, 1'b1},  // R7 enable pending flag
    {1'b0, 3'b000, 3'b000, 1'b1, 8'h00, 1'b0},  // R5 read clears
    {1'b0, 3'b000, 3'b010, 1'b0, 8'h20, 1'b0},  // R3 alarm not enabled
    {1'b0, 3'b000, 3'b001, 1'b1, 8'h10, 1'b0},  // R6 update kept over read
    {1'b1, 3'b001, 3'b000, 1'b0, 8'h90, 1'b1},  // R7 enable update
    {1'b0, 3'b000, 3'b110, 1'b0, 8'hF0, 1'b1},  // R1 multiple sources
    {1'b1, 3'b000, 3'b000, 1'b0, 8'h70, 1'b0},  // R3 all disabled
    {1'b0, 3'b000, 3'b010, 1'b1, 8'h20, 1'b0},  // R6 alarm kept over read
    {1'b1, 3'b111, 3'b000, 1'b1, 8'h00, 1'b0},  // R5 clear with enables on
    {1'b0, 3'b000, 3'b001, 1'b0, 8'h90, 1'b1},  // R3 update asserts
    {1'b0, 3'b000, 3'b000, 1'b0, 8'h90, 1'b1}   // R2 sticky
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
  logic       en_wr = 1'b0;
  logic [2:0] en_wdata = 3'b000;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_q;
  logic       irq_pull;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .en_wr(en_wr), .en_wdata(en_wdata), .stat_rd(stat_rd),
    .stat_q(stat_q), .irq_pull(irq_pull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [2:0] d, input logic [2:0] e, input logic r);
    en_wr = w; en_wdata = d;
    evt_periodic = e[2]; evt_alarm = e[1]; evt_update = e[0];
    stat_rd = r;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 reset state", {stat_q, irq_pull}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][16], VEC[i][15:13], VEC[i][12:10], VEC[i][9]);
      @(negedge clk);
      drive(1'b0, 3'b000, 3'b000, 1'b0);
      chk($sformatf("R1-vector %0d (R3 R4)", i), {stat_q, irq_pull}, VEC[i][8:0]);
    end

    // R5: value presented during the read cycle is the pre-clear state
    drive(1'b0, 3'b000, 3'b000, 1'b1);
    #1;
    chk("R5 read shows flags", {stat_q, irq_pull}, {8'h90, 1'b1});
    @(negedge clk);
    drive(1'b0, 3'b000, 3'b000, 1'b0);
    chk("R5 cleared after read", {stat_q, irq_pull}, 9'h000);

    // R8: reset mid-activity
    drive(1'b0, 3'b000, 3'b111, 1'b0);
    @(negedge clk);
    drive(1'b0, 3'b000, 3'b000, 1'b0);
    chk("R8 pre-reset pending", {stat_q, irq_pull}, {8'hF0, 1'b1});
    rst_n = 1'b0;
    #1;
    chk("R8 during reset", {stat_q, irq_pull}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 3'b000, 3'b100, 1'b0);
    @(negedge clk);
    drive(1'b0, 3'b000, 3'b000, 1'b0);
    chk("R8 enables cleared", {stat_q, irq_pull}, {8'h40, 1'b0});

    // R7: enable alarm only, periodic pending stays quiet; then periodic
    drive(1'b1, 3'b010, 3'b000, 1'b0);
    @(negedge clk);
    drive(1'b0, 3'b000, 3'b000, 1'b0);
    chk("R7 wrong source enabled", {stat_q, irq_pull}, {8'h40, 1'b0});
    drive(1'b1, 3'b100, 3'b000, 1'b0);
    @(negedge clk);
    drive(1'b0, 3'b000, 3'b000, 1'b0);
    chk("R7 periodic enabled", {stat_q, irq_pull}, {8'hC0, 1'b1});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule